// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block drives a six-input successive-approximation converter through a plain request/done handshake. It chooses the input through a channel select, times the settling and conversion phases from a divider setting, and stores each 10-bit result in its own per-channel holding register. Those registers can be read through a small select port.

A scan visits the channels enabled in a mask, lowest number first. In one-shot mode the block goes idle after one pass. In free-run mode it wraps back to the lowest enabled channel on its own. A start pulse begins a scan and a stop pulse ends it, but only once the conversion in flight has finished. The end of each full pass sets a sticky flag and can raise a one-cycle interrupt. A debug-suspend input can pause the sequence between conversions.

The configuration arrives on plain input ports from a register bank outside the block. Mode, mask and divider are captured when a scan begins.

Top module: `adc_scan_seq`

## Requirements
- R1: Each channel slot has three timed phases. Switch settling lasts (d[5:0]+3)*2 cycles, idle setup lasts (d+1)*2 cycles and conversion lasts (d[5:0]+1)*24 cycles, where d is the 16-bit divider. `conv_req` rises after the first two phases, stays high until `conv_done` is seen, and the result is taken on the first cycle that `conv_done` is high after the conversion phase.
- R2: A `start_set` pulse with a non-empty mask makes `busy` and `start_rd` read 1 from the next cycle.
- R3: Only channels whose mask bit is 1 are converted (bit i selects channel i). They are converted in ascending order, and `conv_sel` holds the channel number while `conv_req` is high.
- R4: Each captured `conv_data` is written to the holding register of its channel. `rd_data` shows the register chosen by `rd_sel`, and registers that are not converted keep their values.
- R5: In one-shot mode, after the last enabled channel is captured, `busy` and `start_rd` fall together. With an immediate `conv_done`, a scan of N channels keeps `busy` high for N*(slot length) cycles.
- R6: In free-run mode the scan restarts at the lowest enabled channel with no new start pulse.
- R7: A `start_clr` pulse makes `start_rd` read 0 on the next cycle. The block still completes the current channel slot, then goes idle without starting another.
- R8: The end of each full scan sets `scan_flag`. It also raises `scan_irq` for exactly one cycle when `cfg_scan_ien` is 1. `flag_clr` clears the flag.
- R9: With an all-zero mask, `start_rd` reads 0 and a start pulse is ignored: it neither starts a scan nor is remembered.
- R10: While `emu_suspend` is 1 and `emu_free` is 0, the block pauses after the current conversion with `busy` still high. It continues with the next channel when suspend is released. With `emu_free` set to 1, suspend has no effect.
- R11: Mode, mask and divider are sampled when a scan starts. Changing them while `busy` is high does not alter that scan.
- R12: After reset, `busy`, `start_rd`, `conv_req`, `scan_flag`, `scan_irq` and every holding register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_set | input | 1 | Pulse: request a scan |
| start_clr | input | 1 | Pulse: request a graceful stop |
| cfg_free_run | input | 1 | 1 = free-run, 0 = one-shot |
| cfg_chmask | input | 6 | Channel enable mask |
| cfg_setdiv | input | 16 | Phase timing divider |
| cfg_scan_ien | input | 1 | Scan interrupt enable |
| flag_clr | input | 1 | Pulse: clear scan flag |
| emu_suspend | input | 1 | Debug suspend request |
| emu_free | input | 1 | 1 = ignore suspend |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result |
| rd_sel | input | 3 | Holding register select |
| conv_req | output | 1 | Conversion request |
| conv_sel | output | 3 | Analog input select |
| busy | output | 1 | Sequencer active |
| start_rd | output | 1 | Start state readback |
| scan_flag | output | 1 | Sticky end-of-scan flag |
| scan_irq | output | 1 | One-cycle scan interrupt |
| rd_data | output | 10 | Selected holding register |

## Verification
The properties assume that the mask is not made empty in the cycle a scan begins. They also assume that the converter raises `conv_done` only while `conv_req` is high. The bench's converter model derives `conv_done` from `conv_req` through a gate, so it never answers an idle request. Every mask change in the bench is either made while idle or leaves the mask non-empty.

// File: rtl/adc_seq_pkg.sv
// Shared types for the scan sequencer.
// Assumes nothing beyond a single clock domain.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWSET,
        ST_ADSET,
        ST_CONV,
        ST_WAIT,
        ST_HALT
    } seq_state_t;
endpackage

// File: rtl/adc_phase_timer.sv
// Down-counter that times one phase of a channel slot.
// Loads (length-1) on load; expired is high when the count is zero.
// Assumes the caller loads it on every phase entry.
module adc_phase_timer
    import adc_seq_pkg::*;
#(
    parameter int DIVW  = 16,
    parameter int FINEW = 6,
    parameter int TW    = DIVW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  seq_state_t      phase,
    input  logic [DIVW-1:0] div,
    output logic            expired
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] len;
    logic [TW-1:0] fine;

    assign fine = TW'(div[FINEW-1:0]);

    // Phase length from the divider.
    always_comb begin
        unique case (phase)
            ST_SWSET: len = (fine + TW'(3)) << 1;
            ST_ADSET: len = (TW'(div) + TW'(1)) << 1;
            ST_CONV:  len = (fine + TW'(1)) * TW'(24);
            default:  len = TW'(1);
        endcase
    end

    // Count down to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (load)         cnt <= len - TW'(1);
        else if (cnt != '0)    cnt <= cnt - TW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/adc_chan_pick.sv
// Finds the lowest enabled channel at or above floor_ch.
// Purely combinational; found is 0 when no such channel exists.
module adc_chan_pick #(
    parameter int NCH = 6,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW:0]   floor_ch,
    output logic [CHW-1:0] pick,
    output logic           found
);
    // Scan downward so the lowest qualifying channel wins.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(floor_ch))) begin
                pick  = CHW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// One holding register per channel, written on capture, read by index.
// Assumes wr_ch addresses a valid channel when wr_en is high.
module adc_result_bank #(
    parameter int NCH = 6,
    parameter int DW  = 10,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_sel,
    output logic [DW-1:0]  rd_data
);
    logic [NCH-1:0][DW-1:0] held;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] q;
        // Capture this channel's result.
        always_ff @(posedge clk) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en && (wr_ch == CHW'(g)))    q <= wr_data;
        end
        assign held[g] = q;
    end

    // Read mux; out-of-range selects return zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NCH) rd_data = held[rd_sel];
    end
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer for a multi-input SAR converter.
// Walks the enabled channels, times each slot, captures results,
// and handles one-shot/free-run, graceful stop and debug suspend.
// Assumes conv_done is only asserted while conv_req is high.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int DW    = 10,
    parameter int DIVW  = 16,
    parameter int FINEW = 6,
    localparam int CHW  = $clog2(NCH),
    localparam int TW   = DIVW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_set,
    input  logic            start_clr,
    input  logic            cfg_free_run,
    input  logic [NCH-1:0]  cfg_chmask,
    input  logic [DIVW-1:0] cfg_setdiv,
    input  logic            cfg_scan_ien,
    input  logic            flag_clr,
    input  logic            emu_suspend,
    input  logic            emu_free,
    input  logic            conv_done,
    input  logic [DW-1:0]   conv_data,
    input  logic [CHW-1:0]  rd_sel,
    output logic            conv_req,
    output logic [CHW-1:0]  conv_sel,
    output logic            busy,
    output logic            start_rd,
    output logic            scan_flag,
    output logic            scan_irq,
    output logic [DW-1:0]   rd_data
);
    seq_state_t      st, st_n;
    logic [CHW-1:0]  ch, ch_n;
    logic [NCH-1:0]  lat_mask;
    logic            lat_free;
    logic [DIVW-1:0] lat_div, div_eff;
    logic            start_r, flag_r, irq_r;
    logic            tload, texp, cap, scan_end, relatch, clr_start;
    seq_state_t      tph;
    logic [CHW-1:0]  next_ch, first_cfg;
    logic            has_next, cfg_found, halt_req, go;
    logic [CHW:0]    nxt_floor;

    assign nxt_floor = {1'b0, ch} + (CHW + 1)'(1);
    assign halt_req  = emu_suspend & ~emu_free;
    assign go        = (start_set | start_r) & cfg_found;
    assign div_eff   = relatch ? cfg_setdiv : lat_div;

    adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_next (
        .mask(lat_mask), .floor_ch(nxt_floor), .pick(next_ch), .found(has_next)
    );

    adc_chan_pick #(.NCH(NCH), .CHW(CHW)) u_first (
        .mask(cfg_chmask), .floor_ch('0), .pick(first_cfg), .found(cfg_found)
    );

    adc_phase_timer #(.DIVW(DIVW), .FINEW(FINEW), .TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .phase(tph),
        .div(div_eff), .expired(texp)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cap), .wr_ch(ch),
        .wr_data(conv_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Next-state and slot decisions.
    always_comb begin
        st_n      = st;
        ch_n      = ch;
        tload     = 1'b0;
        tph       = ST_SWSET;
        cap       = 1'b0;
        scan_end  = 1'b0;
        relatch   = 1'b0;
        clr_start = 1'b0;
        unique case (st)
            ST_IDLE: if (go) begin
                st_n = ST_SWSET; ch_n = first_cfg; tload = 1'b1; relatch = 1'b1;
            end
            ST_SWSET: if (texp) begin st_n = ST_ADSET; tload = 1'b1; tph = ST_ADSET; end
            ST_ADSET: if (texp) begin st_n = ST_CONV;  tload = 1'b1; tph = ST_CONV;  end
            ST_CONV:  if (texp) st_n = ST_WAIT;
            ST_WAIT: if (conv_done) begin
                cap      = 1'b1;
                scan_end = !has_next;
                if (!start_r) begin
                    st_n = ST_IDLE;
                end else if (!has_next && (!lat_free || !cfg_found)) begin
                    st_n = ST_IDLE; clr_start = 1'b1;
                end else begin
                    if (has_next) ch_n = next_ch;
                    else begin ch_n = first_cfg; relatch = 1'b1; end
                    if (halt_req) st_n = ST_HALT;
                    else begin st_n = ST_SWSET; tload = 1'b1; end
                end
            end
            ST_HALT: begin
                if (!start_r) st_n = ST_IDLE;
                else if (!halt_req) begin st_n = ST_SWSET; tload = 1'b1; end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Sequencer state, channel and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            ch       <= '0;
            lat_mask <= '0;
            lat_free <= 1'b0;
            lat_div  <= '0;
        end else begin
            st <= st_n;
            ch <= ch_n;
            if (relatch) begin
                lat_mask <= cfg_chmask;
                lat_free <= cfg_free_run;
                lat_div  <= cfg_setdiv;
            end
        end
    end

    // Start request bit: set by a valid start, cleared by stop or one-shot end.
    always_ff @(posedge clk) begin
        if (!rst_n)                        start_r <= 1'b0;
        else if (start_set && cfg_found)   start_r <= 1'b1;
        else if (start_clr || clr_start)   start_r <= 1'b0;
    end

    // Sticky scan flag and one-cycle interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_r <= 1'b0;
            irq_r  <= 1'b0;
        end else begin
            irq_r <= scan_end & cfg_scan_ien;
            if (scan_end)      flag_r <= 1'b1;
            else if (flag_clr) flag_r <= 1'b0;
        end
    end

    assign busy      = (st != ST_IDLE);
    assign conv_req  = (st == ST_CONV) || (st == ST_WAIT);
    assign conv_sel  = ch;
    assign start_rd  = start_r & cfg_found;
    assign scan_flag = flag_r;
    assign scan_irq  = irq_r;
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Property checker bound to the scan sequencer top.
// Assumes the mask is non-empty in the cycle a scan begins.
module adc_scan_seq_chk #(
    parameter int SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_req,
    input logic [SELW-1:0] conv_sel,
    input logic            busy,
    input logic            start_rd,
    input logic            scan_flag,
    input logic            scan_irq
);
    assert_req_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && $past(conv_req)) |-> $stable(conv_sel));

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_rd);

    assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !start_rd);

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |=> !scan_irq);

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_irq |-> scan_flag);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.SELW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_sel(conv_sel),
    .busy(busy), .start_rd(start_rd), .scan_flag(scan_flag), .scan_irq(scan_irq)
);

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_set = 0, start_clr = 0, cfg_free_run = 0, cfg_scan_ien = 1;
    logic [5:0] cfg_chmask = 6'h3F;
    logic [15:0] cfg_setdiv = 16'h0;
    logic flag_clr = 0, emu_suspend = 0, emu_free = 0, done_en = 1;
    logic conv_done;
    logic [9:0] conv_data;
    logic [2:0] rd_sel = 0;
    logic conv_req, busy, start_rd, scan_flag, scan_irq;
    logic [2:0] conv_sel;
    logic [9:0] rd_data;
    logic [6:0] tag = 0;

    int checks = 0, fails = 0;
    int cyc, busy_cnt, busy_first, req_first, irq_cnt, seq_n;
    logic [2:0] seq [64];
    logic req_prev = 0;
    logic [9:0] exp_bank [6];

    always #2.5 clk = ~clk;

    function automatic logic [9:0] model(input logic [2:0] c, input logic [6:0] t);
        return {t, c};
    endfunction

    assign conv_done = conv_req & done_en;
    assign conv_data = model(conv_sel, tag);

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .cfg_free_run(cfg_free_run), .cfg_chmask(cfg_chmask), .cfg_setdiv(cfg_setdiv),
        .cfg_scan_ien(cfg_scan_ien), .flag_clr(flag_clr), .emu_suspend(emu_suspend),
        .emu_free(emu_free), .conv_done(conv_done), .conv_data(conv_data),
        .rd_sel(rd_sel), .conv_req(conv_req), .conv_sel(conv_sel), .busy(busy),
        .start_rd(start_rd), .scan_flag(scan_flag), .scan_irq(scan_irq), .rd_data(rd_data)
    );

    // {mask, divider} one-shot scan vectors
    localparam logic [21:0] VEC [4] = '{
        {6'h3F, 16'h0000}, {6'h05, 16'h0001}, {6'h20, 16'h0102}, {6'h12, 16'h0003}
    };

    function automatic int pre_len(input logic [15:0] d);
        return (int'(d[5:0]) + 3) * 2 + (int'(d) + 1) * 2;
    endfunction
    function automatic int slot_len(input logic [15:0] d);
        return pre_len(d) + (int'(d[5:0]) + 1) * 24 + 1;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (busy) begin busy_cnt++; if (busy_first < 0) busy_first = cyc; end
        if (conv_req && !req_prev) begin
            if (seq_n < 64) seq[seq_n] = conv_sel;
            seq_n++;
            if (req_first < 0) req_first = cyc;
        end
        if (scan_irq) irq_cnt++;
        req_prev = conv_req;
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic clear_mon();
        cyc = 0; busy_cnt = 0; busy_first = -1; req_first = -1; irq_cnt = 0; seq_n = 0;
    endtask

    task automatic tick_start();
        @(posedge clk); #1; start_set = 1; clear_mon();
        @(posedge clk); #1; start_set = 0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1; start_clr = 1;
        @(posedge clk); #1; start_clr = 0;
    endtask

    task automatic pulse_fclr();
        @(posedge clk); #1; flag_clr = 1;
        @(posedge clk); #1; flag_clr = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic check_bank();
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); #1; rd_sel = 3'(c);
            @(negedge clk); chk("R4 bank", int'(rd_data), int'(exp_bank[c]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 6; c++) exp_bank[c] = '0;
        clear_mon();
        repeat (5) @(posedge clk);
        #1; rst_n = 1;
        // R12: reset state
        chk("R12 busy", int'(busy), 0);
        chk("R12 start", int'(start_rd), 0);
        chk("R12 req", int'(conv_req), 0);
        chk("R12 flag", int'(scan_flag), 0);
        chk("R12 irq", int'(scan_irq), 0);
        check_bank();

        // Table of one-shot scans
        for (int v = 0; v < 4; v++) begin
            logic [5:0] m;
            logic [15:0] d;
            int n, k;
            m = VEC[v][21:16]; d = VEC[v][15:0];
            n = $countones(m);
            cfg_chmask = m; cfg_setdiv = d; cfg_free_run = 0; tag = tag + 1;
            tick_start();
            chk("R2 busy", int'(busy), 1);
            chk("R2 start", int'(start_rd), 1);
            wait_idle();
            chk("R5 busy cycles", busy_cnt, n * slot_len(d));
            chk("R1 req offset", req_first - busy_first, pre_len(d));
            chk("R5 start cleared", int'(start_rd), 0);
            chk("R3 count", seq_n, n);
            k = 0;
            for (int c = 0; c < 6; c++) if (m[c]) begin
                chk("R3 order", int'(seq[k]), c);
                k++;
                exp_bank[c] = model(3'(c), tag);
            end
            chk("R8 irq once", irq_cnt, 1);
            chk("R8 flag set", int'(scan_flag), 1);
            pulse_fclr();
            chk("R8 flag clear", int'(scan_flag), 0);
            check_bank();
        end

        // R9: empty mask ignores start
        cfg_chmask = 6'h00;
        chk("R9 start reads 0", int'(start_rd), 0);
        tick_start();
        repeat (5) @(posedge clk); #1;
        chk("R9 busy", int'(busy), 0);
        cfg_chmask = 6'h3F; #1;
        chk("R9 not remembered", int'(start_rd), 0);
        chk("R9 no req", seq_n, 0);

        // R7: graceful stop in one-shot
        cfg_setdiv = 16'h0; tag = tag + 1;
        tick_start();
        repeat (3) @(posedge clk);
        pulse_stop();
        chk("R7 start reads 0", int'(start_rd), 0);
        chk("R7 still busy", int'(busy), 1);
        wait_idle();
        chk("R7 one slot", busy_cnt, slot_len(16'h0));
        chk("R7 one conv", seq_n, 1);
        chk("R7 no flag", int'(scan_flag), 0);
        exp_bank[0] = model(3'd0, tag);
        check_bank();

        // R11: config change mid-scan has no effect
        tag = tag + 1;
        tick_start();
        repeat (5) @(posedge clk); #1;
        cfg_chmask = 6'h01; cfg_setdiv = 16'h0005; cfg_free_run = 1;
        wait_idle();
        chk("R11 count", seq_n, 6);
        chk("R11 cycles", busy_cnt, 6 * slot_len(16'h0));
        for (int c = 0; c < 6; c++) exp_bank[c] = model(3'(c), tag);
        check_bank();

        // R6: free-run wraps
        cfg_chmask = 6'h03; cfg_setdiv = 16'h0; cfg_free_run = 1; tag = tag + 1;
        tick_start();
        while (irq_cnt < 3) @(posedge clk);
        #1;
        chk("R6 busy", int'(busy), 1);
        for (int i = 0; i < 6; i++) chk("R6 wrap order", int'(seq[i]), i % 2);
        pulse_stop();
        chk("R7 free-run start 0", int'(start_rd), 0);
        wait_idle();
        repeat (80) @(posedge clk); #1;
        chk("R7 stays idle", int'(busy), 0);
        exp_bank[0] = model(3'd0, tag); exp_bank[1] = model(3'd1, tag);
        check_bank();
        pulse_fclr();

        // R10: suspend halts between conversions
        cfg_free_run = 0; cfg_chmask = 6'h07; tag = tag + 1;
        emu_suspend = 1; emu_free = 0;
        tick_start();
        repeat (100) @(posedge clk); #1;
        chk("R10 halted busy", int'(busy), 1);
        chk("R10 halted req", int'(conv_req), 0);
        chk("R10 one conv", seq_n, 1);
        emu_suspend = 0;
        wait_idle();
        chk("R10 resumed", seq_n, 3);
        chk("R10 scan irq", irq_cnt, 1);
        for (int c = 0; c < 3; c++) exp_bank[c] = model(3'(c), tag);
        check_bank();
        emu_suspend = 1; emu_free = 1;
        tick_start();
        wait_idle();
        chk("R10 free ignores", busy_cnt, 3 * slot_len(16'h0));
        emu_suspend = 0; emu_free = 0;
        pulse_fclr();

        // R1: request held until done
        cfg_chmask = 6'h01; done_en = 0; tag = tag + 1;
        tick_start();
        repeat (60) @(posedge clk); #1;
        chk("R1 req held", int'(conv_req), 1);
        chk("R1 busy held", int'(busy), 1);
        done_en = 1;
        wait_idle();
        exp_bank[0] = model(3'd0, tag);
        check_bank();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule